// File: doc/BRIEF.md
# Weighted random pattern generator

This block produces pseudo-random test stimulus with controlled signal probabilities. A five-stage linear feedback shift register in internal-XOR form runs the primitive polynomial x^5 + x^2 + 1. It steps through all 31 nonzero states and never reaches the all-zero state. The last stage gives a serial bit stream. The full register is also exposed as a parallel state word.

Five small combinational networks read the register stages. Each drives one output whose probability of being 1 is fixed over a full period: 1/8, 3/8, 1/2, 3/4 or 7/8. Built-in self-test logic feeds these streams to circuit inputs that need biased patterns. A seed can be loaded at any time. An all-zero seed is replaced by the default seed, so the register cannot lock up.

Top module: `wrpg`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets the register to the default seed 10000, read stage 0 first, so `state` = 5'b00001 (`state[i]` is stage i).
- R2: With en high and load low, each rising edge advances the register. Stage 0 takes stage 4. Stage 2 takes stage 1 XOR stage 4. Stages 1, 3 and 4 take stages 0, 2 and 3. `serial` equals stage 4 (`state[4]`).
- R3: From the default seed, the register visits 31 distinct nonzero states while enabled and is back at the seed after exactly 31 steps.
- R4: Outside reset, `state` is never all zero.
- R5: With en low and load low, the register holds its value.
- R6: With load high, a nonzero `seed` is written into the register in one cycle whatever en is. Reset takes priority over load.
- R7: Loading an all-zero `seed` puts the register at 10000 (`state` = 5'b00001) instead.
- R8: The weighted outputs are `w_125` = s0&s1&s2, `w_375` = s2&(s3|s4), `w_500` = s1, `w_750` = s3|s4 and `w_875` = s0|s1|s2, where sN is stage N. Over one full period their counts of 1s are 4, 12, 16, 24 and 28.
- R9: `serial` and the weighted outputs follow the present register value in the same cycle, with no added register stage.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Step the register by one state |
| load | input | 1 | Write `seed` into the register |
| seed | input | 5 (WIDTH) | Seed value; zero is replaced by the default |
| state | output | 5 (WIDTH) | Present register value, bit i is stage i |
| serial | output | 1 | Last-stage bit stream |
| w_125 | output | 1 | Stream with 1-probability 1/8 |
| w_375 | output | 1 | Stream with 1-probability 3/8 |
| w_500 | output | 1 | Stream with 1-probability 1/2 |
| w_750 | output | 1 | Stream with 1-probability 3/4 |
| w_875 | output | 1 | Stream with 1-probability 7/8 |

## Verification
The in-design assertions check on every cycle that the register never holds zero. They also check that a hold leaves it unchanged, that an enabled step moves the last stage into stage 0, that a zero seed lands on the default, and that the low-weight streams imply their high-weight partners. The exact 31-state cycle, the serial sequence from the default seed, the weight counts over a full period and the priority of reset over load and of load over enable can only be shown by the bench's directed and random scenarios, compared against its own model.

// File: rtl/wrpg_pkg.sv
package wrpg_pkg;

   // Combining function used by one weighting network
   typedef enum logic [2:0] {
      WK_PASS    = 3'd0,   // a            -> 1/2
      WK_AND3    = 3'd1,   // a & b & c    -> 1/8
      WK_OR3     = 3'd2,   // a | b | c    -> 7/8
      WK_OR2     = 3'd3,   // a | b        -> 3/4
      WK_AND_OR  = 3'd4    // a & (b | c)  -> 3/8
   } weight_kind_e;

endpackage

// File: rtl/wrpg_lfsr.sv
module wrpg_lfsr #(
   parameter int               WIDTH        = 5,
   parameter logic [WIDTH-1:0] TAPS         = 5'b00100,
   parameter logic [WIDTH-1:0] DEFAULT_SEED = 5'b00001
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             load,
   input  logic [WIDTH-1:0] seed,
   output logic [WIDTH-1:0] state
);

   localparam int LAST = WIDTH - 1;

   logic [WIDTH-1:0] q;
   logic [WIDTH-1:0] nxt;
   logic [WIDTH-1:0] load_val;

   initial begin
      assert (WIDTH >= 2) else $fatal(1, "wrpg_lfsr: WIDTH too small");
      assert (DEFAULT_SEED != '0) else $fatal(1, "wrpg_lfsr: zero default seed");
      assert (TAPS[0] == 1'b0) else $fatal(1, "wrpg_lfsr: stage 0 takes no tap");
   end

   // Internal-XOR feedback: the last stage returns to stage 0 and is
   // mixed into every stage whose tap bit is set.
   generate
      for (genvar i = 0; i < WIDTH; i++) begin : g_stage
         if (i == 0) begin : g_head
            assign nxt[i] = q[LAST];
         end else if (TAPS[i]) begin : g_tap
            assign nxt[i] = q[i-1] ^ q[LAST];
         end else begin : g_plain
            assign nxt[i] = q[i-1];
         end
      end
   endgenerate

   // A zero seed would freeze the register; substitute the default.
   assign load_val = (seed == '0) ? DEFAULT_SEED : seed;

   always_ff @(posedge clk) begin
      if (rst)       q <= DEFAULT_SEED;
      else if (load) q <= load_val;
      else if (en)   q <= nxt;
   end

   assign state = q;

   AST_NEVER_ZERO: assert property (@(posedge clk) disable iff (rst)
      q != '0);                                                        // R4
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
      (!en && !load) |=> $stable(q));                                  // R5
   AST_FEEDBACK_HEAD: assert property (@(posedge clk) disable iff (rst)
      (en && !load) |=> (q[0] == $past(q[LAST])));                     // R2
   AST_ZERO_SEED: assert property (@(posedge clk) disable iff (rst)
      (load && seed == '0) |=> (q == DEFAULT_SEED));                   // R7

endmodule

// File: rtl/wrpg_weight_net.sv
module wrpg_weight_net
   import wrpg_pkg::*;
#(
   parameter int           WIDTH = 5,
   parameter weight_kind_e KIND  = WK_PASS,
   parameter int           IA    = 0,
   parameter int           IB    = 1,
   parameter int           IC    = 2
) (
   input  logic [WIDTH-1:0] stages,
   output logic             out
);

   logic a, b, c;
   logic unused_stages;

   initial begin
      assert (IA >= 0 && IA < WIDTH && IB >= 0 && IB < WIDTH && IC >= 0 && IC < WIDTH)
         else $fatal(1, "wrpg_weight_net: stage index out of range");
      assert (IA != IB && IB != IC && IA != IC)
         else $fatal(1, "wrpg_weight_net: stages must be distinct");
   end

   assign a = stages[IA];
   assign b = stages[IB];
   assign c = stages[IC];
   assign unused_stages = ^stages;

   generate
      case (KIND)
         WK_AND3:   begin : g_and3   assign out = a & b & c;   end
         WK_OR3:    begin : g_or3    assign out = a | b | c;   end
         WK_OR2:    begin : g_or2    assign out = a | b;       end
         WK_AND_OR: begin : g_and_or assign out = a & (b | c); end
         default:   begin : g_pass   assign out = a;           end
      endcase
   endgenerate

endmodule

// File: rtl/wrpg.sv
module wrpg
   import wrpg_pkg::*;
#(
   parameter int               WIDTH        = 5,
   parameter logic [WIDTH-1:0] TAPS         = 5'b00100,
   parameter logic [WIDTH-1:0] DEFAULT_SEED = 5'b00001
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             en,
   input  logic             load,
   input  logic [WIDTH-1:0] seed,
   output logic [WIDTH-1:0] state,
   output logic             serial,
   output logic             w_125,
   output logic             w_375,
   output logic             w_500,
   output logic             w_750,
   output logic             w_875
);

   localparam int NUM_W = 5;
   localparam int LAST  = WIDTH - 1;

   // Per-stream combining function and stage selection
   localparam weight_kind_e W_KIND [NUM_W] = '{WK_AND3, WK_AND_OR, WK_PASS, WK_OR2, WK_OR3};
   localparam int           W_IA   [NUM_W] = '{0, 2, 1, 3, 0};
   localparam int           W_IB   [NUM_W] = '{1, 3, 0, 4, 1};
   localparam int           W_IC   [NUM_W] = '{2, 4, 2, 0, 2};

   logic [NUM_W-1:0] wbits;

   initial begin
      assert (WIDTH >= 5) else $fatal(1, "wrpg: weighting networks need five stages");
   end

   wrpg_lfsr #(
      .WIDTH        (WIDTH),
      .TAPS         (TAPS),
      .DEFAULT_SEED (DEFAULT_SEED)
   ) u_lfsr (
      .clk   (clk),
      .rst   (rst),
      .en    (en),
      .load  (load),
      .seed  (seed),
      .state (state)
   );

   generate
      for (genvar k = 0; k < NUM_W; k++) begin : g_wnet
         wrpg_weight_net #(
            .WIDTH (WIDTH),
            .KIND  (W_KIND[k]),
            .IA    (W_IA[k]),
            .IB    (W_IB[k]),
            .IC    (W_IC[k])
         ) u_net (
            .stages (state),
            .out    (wbits[k])
         );
      end
   endgenerate

   assign serial = state[LAST];
   assign w_125  = wbits[0];
   assign w_375  = wbits[1];
   assign w_500  = wbits[2];
   assign w_750  = wbits[3];
   assign w_875  = wbits[4];

   AST_LOW_IMPLIES_HIGH: assert property (@(posedge clk) disable iff (rst)
      w_125 |-> w_875);                                                // R8
   AST_MID_IMPLIES_UPPER: assert property (@(posedge clk) disable iff (rst)
      w_375 |-> w_750);                                                // R8
   AST_SERIAL_IS_LAST: assert property (@(posedge clk) disable iff (rst)
      serial == state[LAST]);                                          // R9

endmodule

// File: tb/wrpg_bench.sv
module wrpg_bench;

   localparam int CLK_PERIOD = 10;
   localparam logic [4:0] DEF = 5'b00001;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       en = 1'b0;
   logic       load = 1'b0;
   logic [4:0] seed = '0;
   logic [4:0] state;
   logic       serial, w_125, w_375, w_500, w_750, w_875;

   int n_checks = 0;
   int n_fail   = 0;
   bit done     = 1'b0;
   logic [4:0] m;   // bench model of the register

   always #(CLK_PERIOD/2) clk = ~clk;

   wrpg u_wrpg (
      .clk(clk), .rst(rst), .en(en), .load(load), .seed(seed),
      .state(state), .serial(serial),
      .w_125(w_125), .w_375(w_375), .w_500(w_500), .w_750(w_750), .w_875(w_875)
   );

   function automatic logic [4:0] ref_next(input logic [4:0] s);
      return {s[3], s[2], s[1] ^ s[4], s[0], s[4]};
   endfunction

   // {w_875, w_750, w_500, w_375, w_125}
   function automatic logic [4:0] ref_w(input logic [4:0] s);
      return {s[0] | s[1] | s[2], s[3] | s[4], s[1], s[2] & (s[3] | s[4]), s[0] & s[1] & s[2]};
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // Called at a falling edge: drive, pass one rising edge, return at the next falling edge.
   task automatic step(input logic r, input logic e, input logic l, input logic [4:0] sd);
      rst = r; en = e; load = l; seed = sd;
      @(posedge clk);
      @(negedge clk);
      if (r)      m = DEF;
      else if (l) m = (sd == 5'd0) ? DEF : sd;
      else if (e) m = ref_next(m);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin
      bit   seen [32];
      int   cnt [5];
      logic [4:0] wexp;
      logic [4:0] hold_v;
      void'($urandom(32'd20240607));
      m = DEF;
      @(negedge clk);
      step(1'b1, 1'b0, 1'b0, 5'd0);
      step(1'b1, 1'b1, 1'b0, 5'd0);
      chk("R1 reset state", state, DEF);

      // R2: first 16 serial bits from the default seed
      step(1'b0, 1'b0, 1'b0, 5'd0);
      for (int k = 0; k < 16; k++) begin
         chk("R2 serial bit", serial, m[4]);
         chk("R2 state step", state, m);
         step(1'b0, 1'b1, 1'b0, 5'd0);
      end

      // R3/R4/R8: one full period
      step(1'b1, 1'b0, 1'b0, 5'd0);
      step(1'b0, 1'b0, 1'b0, 5'd0);
      for (int i = 0; i < 32; i++) seen[i] = 1'b0;
      for (int i = 0; i < 5; i++) cnt[i] = 0;
      for (int k = 0; k < 31; k++) begin
         chk("R4 state nonzero", (state != 5'd0), 1);
         chk("R3 state distinct", seen[state], 0);
         seen[state] = 1'b1;
         wexp = ref_w(state);
         chk("R8 weights", {w_875, w_750, w_500, w_375, w_125}, wexp);
         cnt[0] += w_125; cnt[1] += w_375; cnt[2] += w_500;
         cnt[3] += w_750; cnt[4] += w_875;
         step(1'b0, 1'b1, 1'b0, 5'd0);
      end
      chk("R3 period returns to seed", state, DEF);
      chk("R8 count w_125", cnt[0], 4);
      chk("R8 count w_375", cnt[1], 12);
      chk("R8 count w_500", cnt[2], 16);
      chk("R8 count w_750", cnt[3], 24);
      chk("R8 count w_875", cnt[4], 28);

      // R5: hold
      step(1'b0, 1'b1, 1'b0, 5'd0);
      step(1'b0, 1'b1, 1'b0, 5'd0);
      hold_v = state;
      for (int k = 0; k < 4; k++) begin
         step(1'b0, 1'b0, 1'b0, 5'd0);
         chk("R5 hold", state, hold_v);
      end

      // R6: load with and without enable, reset over load
      step(1'b0, 1'b0, 1'b1, 5'b10110);
      chk("R6 load en low", state, 5'b10110);
      step(1'b0, 1'b1, 1'b1, 5'b01011);
      chk("R6 load over enable", state, 5'b01011);
      step(1'b1, 1'b1, 1'b1, 5'b11111);
      chk("R6 reset over load", state, DEF);

      // R7: zero seed is replaced
      step(1'b0, 1'b0, 1'b1, 5'b11100);
      step(1'b0, 1'b1, 1'b1, 5'd0);
      chk("R7 zero seed", state, DEF);

      // Random traffic against the model
      for (int k = 0; k < 400; k++) begin
         logic r, e, l;
         logic [4:0] sd;
         r  = ($urandom_range(99) < 3);
         e  = ($urandom_range(99) < 70);
         l  = ($urandom_range(99) < 10);
         sd = 5'($urandom_range(31));
         if ($urandom_range(9) == 0) sd = 5'd0;
         step(r, e, l, sd);
         chk("R2 random state", state, m);
         chk("R9 random serial", serial, m[4]);
         chk("R8 random weights", {w_875, w_750, w_500, w_375, w_125}, ref_w(m));
      end

      finish_run();
   end

endmodule